// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Scanner

This block produces the scan for one passive dot-matrix LCD driver with 80 output pins. Each pin gets a 3-bit code that picks one of six drive levels (V0 to V5). A two-bit mode input divides the pins between row electrodes (commons) and column electrodes (segments), and so sets the duty. A master/slave input chooses where the line timing comes from. A master makes its own line strobe from the clock and drives it out. A slave steps its rows only on a strobe taken in from the master, and uses all 80 of its pins as segments. Several chips can therefore share one panel.

For each row, the block reads that row's pixel nibbles from an external synchronous display RAM. It does this during the previous row period and holds them in a shadow register. On the line strobe the whole shadow moves to the display register in one step. Each pin's level code then follows from four things: whether the pin is a common or a segment, whether the common is the one selected, the pixel bit, and the frame polarity. The polarity flips each time the row counter returns to the first row.

Top module: `lcd_scan`

## Requirements
- R1: In master mode, `mode_sel` divides pins 0..79 into segments (low pins) and commons (high pins), as follows: 00 gives 16 segments and 64 commons, 01 gives 0 segments and 80 commons, 10 gives 32 segments and 48 commons, 11 gives 48 segments and 32 commons. Pin p < nseg shows segment p+1. Pin p ≥ nseg shows common p−nseg+1.
- R2: In slave mode (`master_en`=0), all 80 pins are segments, and the row count still follows `mode_sel` (64, 80, 48 or 32 rows).
- R3: A master drives `load_out` high for exactly one cycle every LINE_CYCLES clocks. A slave keeps `load_out` at 0.
- R4: A master advances one row per `load_out` pulse and ignores `load_in`. A slave advances only when it samples `load_in` high; with no strobe, its outputs do not change. `level_out` and `frame_neg` show the new row from the second rising edge after the strobe is seen high.
- R5: The row counter counts 0..ncom−1 and then wraps to 0, where ncom is the common count of the mode.
- R6: Polarity (`frame_neg`, 0 = positive) toggles at each wrap from the last row to row 0, and at no other time.
- R7: Level codes (0..5 = V0..V5) in a positive / negative frame: selected common 0/5, unselected common 4/1, lit segment 5/0, dark segment 3/2.
- R8: Row k (0-based) starts at RAM address 32·k. Nibble j (0..19) of the row holds segments 80−4j down to 77−4j in bits 3..0. A bit of 1 means lit and 0 means dark.
- R9: The data for a row is fetched during the preceding row period. Outputs change only on a row advance, never while a fetch is in progress.
- R10: After reset: row 0 is selected, polarity is positive, every segment is dark, and `load_out` is 0.
- R11: `ram_rd` requests one nibble per cycle. `ram_rdata` is sampled one cycle after the request. Only nibble offsets 0..19 within a row are read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Common/segment split and duty select |
| master_en | input | 1 | 1 = master timing, 0 = slave following `load_in` |
| load_in | input | 1 | Line strobe from a master (slave only) |
| load_out | output | 1 | Line strobe generated by a master |
| ram_rd | output | 1 | Display RAM read request |
| ram_addr | output | 12 | Display RAM nibble address |
| ram_rdata | input | 4 | Display RAM read data, one cycle after request |
| frame_neg | output | 1 | Current frame polarity, 1 = negative |
| level_out | output | 240 | Per-pin level code, pin p at bits 3p+2..3p |

## Verification
The hardest point to reach is the polarity flip. It needs a complete frame of up to 80 line strobes before the row counter wraps. The row shown just after the wrap must also carry row 0's data, which was fetched during the last row of the previous frame. The bench runs every master mode for a few rows past ncom and checks every pin on every cycle. In slave mode it drives strobes by hand with uneven gaps, including one long quiet stretch, so the wrap comes from the counted strobes alone.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  // Drive level codes 0..5 select V0..V5
  typedef enum logic [2:0] {
    LV0 = 3'd0, LV1 = 3'd1, LV2 = 3'd2, LV3 = 3'd3, LV4 = 3'd4, LV5 = 3'd5
  } level_t;

  // Number of segment pins for a mode; a slave uses every pin as a segment
  function automatic logic [7:0] seg_count(input logic [1:0] m, input logic master);
    logic [7:0] n;
    case (m)
      2'b00:   n = 8'd16;
      2'b01:   n = 8'd0;
      2'b10:   n = 8'd32;
      default: n = 8'd48;
    endcase
    return master ? n : 8'd80;
  endfunction

  // Number of scanned rows (duty denominator) for a mode
  function automatic logic [7:0] com_count(input logic [1:0] m);
    case (m)
      2'b00:   return 8'd64;
      2'b01:   return 8'd80;
      2'b10:   return 8'd48;
      default: return 8'd32;
    endcase
  endfunction

endpackage

// File: rtl/lcd_line_timer.sv
module lcd_line_timer #(
  parameter int LINE_CYCLES = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic master_en,
  output logic load_out
);
  localparam int CW = (LINE_CYCLES > 1) ? $clog2(LINE_CYCLES) : 1;

  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == CW'(LINE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      load_out <= 1'b0;
    end else if (!master_en) begin
      cnt      <= '0;
      load_out <= 1'b0;
    end else begin
      cnt      <= last ? '0 : cnt + 1'b1;
      load_out <= last;
    end
  end
endmodule

// File: rtl/lcd_row_seq.sv
module lcd_row_seq #(
  parameter int ROW_W = 7,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [CNT_W-1:0] com_total,
  output logic [ROW_W-1:0] cur_row,
  output logic [ROW_W-1:0] next_row,
  output logic             pol_neg
);
  logic at_last;

  assign at_last  = (CNT_W'(cur_row) + CNT_W'(1)) >= com_total;
  assign next_row = at_last ? '0 : cur_row + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_row <= '0;
      pol_neg <= 1'b0;
    end else if (adv) begin
      cur_row <= next_row;
      if (at_last) pol_neg <= ~pol_neg;
    end
  end
endmodule

// File: rtl/lcd_row_fetch.sv
module lcd_row_fetch #(
  parameter int NUM_OUT    = 80,
  parameter int DW         = 4,
  parameter int AW         = 12,
  parameter int ROW_STRIDE = 32,
  parameter int ROW_W      = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ROW_W-1:0]   fetch_row,
  output logic               ram_rd,
  output logic [AW-1:0]      ram_addr,
  input  logic [DW-1:0]      ram_rdata,
  output logic [NUM_OUT-1:0] shadow
);
  localparam int NIBS = NUM_OUT / DW;
  localparam int IW   = (NIBS > 1) ? $clog2(NIBS) : 1;

  logic             busy;
  logic [IW-1:0]    idx;
  logic [IW-1:0]    idx_q;
  logic [ROW_W-1:0] base_row;
  logic             cap_v;
  logic [IW-1:0]    cap_idx;

  // Address issue: one nibble per cycle while busy
  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      idx      <= '0;
      idx_q    <= '0;
      base_row <= '0;
      ram_rd   <= 1'b0;
      ram_addr <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      idx      <= '0;
      base_row <= fetch_row;
      ram_rd   <= 1'b0;
    end else if (busy) begin
      ram_rd   <= 1'b1;
      ram_addr <= AW'(base_row) * AW'(ROW_STRIDE) + AW'(idx);
      idx_q    <= idx;
      idx      <= idx + 1'b1;
      if (idx == IW'(NIBS - 1)) busy <= 1'b0;
    end else begin
      ram_rd <= 1'b0;
    end
  end

  // Capture: read data is valid one cycle after the request
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_v   <= 1'b0;
      cap_idx <= '0;
      shadow  <= '0;
    end else begin
      cap_v   <= ram_rd;
      cap_idx <= idx_q;
      for (int j = 0; j < NIBS; j++) begin
        if (cap_v && cap_idx == IW'(j))
          shadow[NUM_OUT-1-DW*j -: DW] <= ram_rdata;
      end
    end
  end
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
  import lcd_scan_pkg::*;
#(
  parameter int NUM_OUT = 80,
  parameter int ROW_W   = 7,
  parameter int CNT_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_OUT-1:0]   disp,
  input  logic [ROW_W-1:0]     cur_row,
  input  logic                 pol_neg,
  input  logic [CNT_W-1:0]     seg_total,
  output logic [3*NUM_OUT-1:0] level_out,
  output logic                 frame_neg
);
  always_ff @(posedge clk) begin
    if (rst) frame_neg <= 1'b0;
    else     frame_neg <= pol_neg;
  end

  for (genvar p = 0; p < NUM_OUT; p++) begin : g_pin
    logic       is_seg;
    logic       is_sel;
    logic [CNT_W-1:0] cidx;
    level_t     code;

    assign cidx   = CNT_W'(p) - seg_total;
    assign is_seg = CNT_W'(p) < seg_total;
    assign is_sel = (cidx == CNT_W'(cur_row));

    always_comb begin
      if (is_seg) begin
        if (disp[p]) code = pol_neg ? LV0 : LV5;
        else         code = pol_neg ? LV2 : LV3;
      end else begin
        if (is_sel)  code = pol_neg ? LV5 : LV0;
        else         code = pol_neg ? LV1 : LV4;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) level_out[3*p +: 3] <= 3'd0;
      else     level_out[3*p +: 3] <= code;
    end
  end
endmodule

// File: rtl/lcd_scan.sv
module lcd_scan
  import lcd_scan_pkg::*;
#(
  parameter int NUM_OUT     = 80,
  parameter int DW          = 4,
  parameter int AW          = 12,
  parameter int ROW_STRIDE  = 32,
  parameter int LINE_CYCLES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           mode_sel,
  input  logic                 master_en,
  input  logic                 load_in,
  output logic                 load_out,
  output logic                 ram_rd,
  output logic [AW-1:0]        ram_addr,
  input  logic [DW-1:0]        ram_rdata,
  output logic                 frame_neg,
  output logic [3*NUM_OUT-1:0] level_out
);
  localparam int ROW_W = $clog2(NUM_OUT);
  localparam int CNT_W = 8;

  logic [CNT_W-1:0]   seg_total;
  logic [CNT_W-1:0]   com_total;
  logic               adv;
  logic               start_q;
  logic [ROW_W-1:0]   cur_row;
  logic [ROW_W-1:0]   next_row;
  logic               pol_neg;
  logic [NUM_OUT-1:0] shadow;
  logic [NUM_OUT-1:0] disp;

  assign seg_total = seg_count(mode_sel, master_en);
  assign com_total = com_count(mode_sel);
  assign adv       = master_en ? load_out : load_in;

  lcd_line_timer #(.LINE_CYCLES(LINE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .master_en(master_en), .load_out(load_out)
  );

  lcd_row_seq #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .adv(adv), .com_total(com_total),
    .cur_row(cur_row), .next_row(next_row), .pol_neg(pol_neg)
  );

  // Fetch of the following row starts the cycle after each advance
  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b1;
    else     start_q <= adv;
  end

  lcd_row_fetch #(
    .NUM_OUT(NUM_OUT), .DW(DW), .AW(AW), .ROW_STRIDE(ROW_STRIDE), .ROW_W(ROW_W)
  ) u_fetch (
    .clk(clk), .rst(rst), .start(start_q), .fetch_row(next_row),
    .ram_rd(ram_rd), .ram_addr(ram_addr), .ram_rdata(ram_rdata), .shadow(shadow)
  );

  // Whole-row transfer from shadow on the line strobe
  always_ff @(posedge clk) begin
    if (rst)      disp <= '0;
    else if (adv) disp <= shadow;
  end

  lcd_level_enc #(.NUM_OUT(NUM_OUT), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_enc (
    .clk(clk), .rst(rst), .disp(disp), .cur_row(cur_row), .pol_neg(pol_neg),
    .seg_total(seg_total), .level_out(level_out), .frame_neg(frame_neg)
  );
endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk
  import lcd_scan_pkg::*;
#(
  parameter int AW         = 12,
  parameter int ROW_STRIDE = 32,
  parameter int NIBS       = 20,
  parameter int ROW_W      = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_sel,
  input logic             master_en,
  input logic             load_out,
  input logic             adv,
  input logic [ROW_W-1:0] cur_row,
  input logic             pol_neg,
  input logic             ram_rd,
  input logic [AW-1:0]    ram_addr
);
  logic wrap_now;
  assign wrap_now = adv && ((8'(cur_row) + 8'd1) == com_count(mode_sel));

  AST_SLAVE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !master_en |-> !load_out);                                               // R3
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    load_out |=> !load_out);                                                 // R3
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cur_row));                                              // R4
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
    8'(cur_row) < com_count(mode_sel));                                      // R5
  AST_POL_FLIP: assert property (@(posedge clk) disable iff (rst)
    wrap_now |=> pol_neg != $past(pol_neg));                                 // R6
  AST_POL_KEEP: assert property (@(posedge clk) disable iff (rst)
    !wrap_now |=> $stable(pol_neg));                                         // R6
  AST_RD_OFFSET: assert property (@(posedge clk) disable iff (rst)
    ram_rd |-> (32'(ram_addr) % ROW_STRIDE) < NIBS);                         // R11
endmodule

bind lcd_scan lcd_scan_chk #(
  .AW(AW), .ROW_STRIDE(ROW_STRIDE), .NIBS(NUM_OUT / DW), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .master_en(master_en),
  .load_out(load_out), .adv(adv), .cur_row(cur_row), .pol_neg(pol_neg),
  .ram_rd(ram_rd), .ram_addr(ram_addr)
);

// File: tb/lcd_scan_bench.sv
module lcd_scan_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int LINE_CYCLES = 32;
  localparam int NPIN        = 80;
  localparam int RAM_DEPTH   = 2560;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode_sel = 2'b00;
  logic         master_en = 1'b1;
  logic         load_in = 1'b0;
  logic         load_out;
  logic         ram_rd;
  logic [11:0]  ram_addr;
  logic [3:0]   ram_rdata;
  logic         frame_neg;
  logic [239:0] level_out;

  logic [3:0] mem [RAM_DEPTH];

  int n_chk = 0;
  int n_bad = 0;

  // expected-state tracking
  int   exp_row, pend, gap, seed_g, row_bad_cnt;
  bit   exp_neg, exp_zero, first_load, row_err, load_err;
  logic [239:0] bad_act, bad_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_scan u_lcd_scan (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .master_en(master_en),
    .load_in(load_in), .load_out(load_out), .ram_rd(ram_rd),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata), .frame_neg(frame_neg),
    .level_out(level_out)
  );

  always_ff @(posedge clk)
    if (ram_rd) ram_rdata <= (ram_addr < RAM_DEPTH) ? mem[ram_addr] : 4'h0;

  function automatic int seg_n(logic [1:0] m, bit mst);
    if (!mst) return 80;
    case (m) 2'b00: return 16; 2'b01: return 0; 2'b10: return 32; default: return 48; endcase
  endfunction

  function automatic int com_n(logic [1:0] m);
    case (m) 2'b00: return 64; 2'b01: return 80; 2'b10: return 48; default: return 32; endcase
  endfunction

  function automatic bit pix(int r, int s, int seed);
    return (((r * 5) + (s * 3) + seed + (r * s) % 11) % 7) < 3;
  endfunction

  function automatic logic [239:0] exp_vec(logic [1:0] m, bit mst, int row, bit neg,
                                           bit zero, int seed);
    logic [239:0] v;
    int nseg;
    nseg = seg_n(m, mst);
    v = '0;
    for (int p = 0; p < NPIN; p++) begin
      logic [2:0] c;
      if (p < nseg) begin
        if (!zero && pix(row, p + 1, seed)) c = neg ? 3'd0 : 3'd5;
        else                                c = neg ? 3'd2 : 3'd3;
      end else begin
        if (p - nseg == row) c = neg ? 3'd5 : 3'd0;
        else                 c = neg ? 3'd1 : 3'd4;
      end
      v[3*p +: 3] = c;
    end
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, logic [239:0] act, logic [239:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // RAM layout per R8: row k at 32*k, nibble j bit b = segment 77-4j+b
  task automatic fill_ram(int seed);
    for (int r = 0; r < NPIN; r++)
      for (int j = 0; j < 32; j++) begin
        logic [3:0] nib;
        nib = 4'hA;
        if (j < 20)
          for (int b = 0; b < 4; b++) nib[b] = pix(r, 77 - 4*j + b, seed);
        mem[32*r + j] = nib;
      end
  endtask

  task automatic do_reset(logic [1:0] m, bit mst, int seed);
    fill_ram(seed);
    seed_g = seed;
    @(negedge clk);
    rst = 1'b1; mode_sel = m; master_en = mst; load_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_row = 0; exp_neg = 1'b0; exp_zero = 1'b1; pend = 0; gap = 0;
    first_load = 1'b1; row_err = 1'b0; load_err = 1'b0; row_bad_cnt = 0;
    @(negedge clk);
  endtask

  // One cycle: advance expectations, compare every pin (R1/R7/R8/R9)
  task automatic step(string tag);
    logic [239:0] e;
    @(negedge clk);
    load_in = 1'b0;
    gap++;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        check(!row_err, tag, $sformatf("row %0d levels steady and correct (R9)", exp_row),
              bad_act, bad_exp);
        row_err = 1'b0;
        if (exp_row + 1 >= com_n(mode_sel)) begin exp_row = 0; exp_neg = ~exp_neg; end
        else exp_row++;
        exp_zero = 1'b0;
        row_bad_cnt++;
      end
    end
    e = exp_vec(mode_sel, master_en, exp_row, exp_neg, exp_zero, seed_g);
    if (level_out !== e || frame_neg !== exp_neg) begin
      if (!row_err) begin bad_act = level_out; bad_exp = e; end
      row_err = 1'b1;
    end
    if (master_en) begin
      if (load_out === 1'b1) begin
        if (!first_load)
          check(gap == LINE_CYCLES, "R3", "load_out period", 240'(gap), 240'(LINE_CYCLES));
        first_load = 1'b0;
        gap = 0;
        pend = 2;
      end
    end else if (load_out !== 1'b0) load_err = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset(2'b00, 1'b1, 3);
    repeat (2) @(negedge clk);
    check(level_out === exp_vec(2'b00, 1'b1, 0, 1'b0, 1'b1, 3), "R10",
          "reset levels", level_out, exp_vec(2'b00, 1'b1, 0, 1'b0, 1'b1, 3));
    check(load_out === 1'b0, "R10", "reset load_out", 240'(load_out), 240'(0));
    check(frame_neg === 1'b0, "R10", "reset polarity", 240'(frame_neg), 240'(0));
  endtask

  task automatic t_master(logic [1:0] m, int seed);
    int target;
    string tag;
    tag = $sformatf("R1/R5/R6/R7/R8 master mode %0d", m);
    do_reset(m, 1'b1, seed);
    target = com_n(m) + 3;
    for (int cyc = 0; row_bad_cnt < target && cyc < 4000; cyc++) begin
      step(tag);
      // R4: master ignores strobe input
      if (cyc % 7 == 3) load_in = 1'b1;
    end
    check(row_bad_cnt == target, "R5", "master rows advanced", 240'(row_bad_cnt), 240'(target));
    check(exp_neg == 1'b1 && frame_neg === 1'b1, "R6", "polarity after one wrap",
          240'(frame_neg), 240'(1));
  endtask

  task automatic t_slave(logic [1:0] m, int seed, int nloads);
    string tag;
    tag = $sformatf("R2/R4/R7/R8 slave mode %0d", m);
    do_reset(m, 1'b0, seed);
    for (int l = 0; l < nloads; l++) begin
      int idle;
      idle = (l == 5) ? 150 : 30 + (l % 3) * 5;
      for (int i = 0; i < idle; i++) step(tag);
      if (l == 5)
        check(level_out === exp_vec(m, 1'b0, exp_row, exp_neg, exp_zero, seed), "R4",
              "slave holds without strobe", level_out,
              exp_vec(m, 1'b0, exp_row, exp_neg, exp_zero, seed));
      load_in = 1'b1;
      pend = 2;
    end
    repeat (4) step(tag);
    check(row_bad_cnt == nloads, "R2", "slave rows advanced", 240'(row_bad_cnt), 240'(nloads));
    check(exp_neg == 1'b1 && frame_neg === 1'b1, "R6", "slave polarity after wrap",
          240'(frame_neg), 240'(1));
    check(!load_err, "R3", "slave load_out stays low", 240'(load_err), 240'(0));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion (R4)");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_master(2'b00, 1);
    t_master(2'b01, 2);
    t_master(2'b10, 4);
    t_master(2'b11, 6);
    t_slave(2'b11, 9, 35);   // R11 row data read through the RAM port in every test
    t_slave(2'b10, 13, 50);
    finish_run();
  end
endmodule